// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block sizes the first instruction in a 16-byte fetch window that starts on an instruction boundary. It steps through the optional parts of a variable-length CISC encoding in order: legacy prefixes, an optional REX byte, one to three opcode bytes selected by escape bytes, an optional ModR/M byte, an optional SIB byte, a displacement and an immediate. It returns the total byte count, which a fetch stage uses to find where the next instruction starts.

The opcode coverage is deliberately narrow. It handles the move-immediate-to-register/memory form (0xC7), the move-immediate form that encodes the register in the low opcode bits (0xB8–0xBF), and a generic class for every other one-byte opcode that carries a ModR/M byte. It also handles the three escaped maps. Addressing is always sized as 32-bit. The 0x67 prefix is counted as a byte but does not change any field size.

One window is accepted per cycle when `in_valid` is high. The length and a fault flag are registered and appear one cycle later with `out_valid`. A fault means the encoding would be longer than 15 bytes, or that it carries too many legacy prefixes.

Top module: `insn_len_decoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `len_o` and `fault_o` are all 0.
- R2: `out_valid` is high exactly one cycle after `in_valid` was high. When `in_valid` is low, `len_o` and `fault_o` keep their last values.
- R3: The bytes 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66, 0x67, 0xF0, 0xF2 and 0xF3 are legacy prefixes. Up to four of them at the start of the window each add one byte. A fifth consecutive legacy prefix raises a fault.
- R4: A byte in 0x40–0x4F that directly follows the legacy prefixes is a REX byte and adds one byte. Its bit 3 is the W (64-bit operand) flag. The next byte is always the opcode.
- R5: Opcode length is 1 byte. It is 2 bytes when the first opcode byte is 0x0F. It is 3 bytes when 0x0F is followed by 0x38 or 0x3A.
- R6: One-byte opcode 0xC7 has a ModR/M byte. Its immediate is 4 bytes when REX.W is set. It is 2 bytes when 0x66 is present without REX.W. Otherwise it is 4 bytes.
- R7: One-byte opcodes 0xB8–0xBF have no ModR/M byte. Their immediate is 8 bytes when REX.W is set, 2 bytes when 0x66 is present without REX.W, and 4 bytes otherwise.
- R8: Every other one-byte opcode, and every opcode in the 0x0F and 0x0F 0x38 maps, has a ModR/M byte and no immediate. Opcodes in the 0x0F 0x3A map have a ModR/M byte and a 1-byte immediate.
- R9: A SIB byte follows the ModR/M byte when mod (bits 7:6) is not 3 and rm (bits 2:0) is 4.
- R10: Displacement is 1 byte when mod is 1 and 4 bytes when mod is 2. It is also 4 bytes when mod is 0 and either rm is 5, or a SIB byte is present with base (bits 2:0) equal to 5. Otherwise there is no displacement.
- R11: When the summed length exceeds 15, or a fault from R3 applies, `fault_o` is 1 and `len_o` is 0. Otherwise `fault_o` is 0 and `len_o` is the length, from 1 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window valid strobe |
| win_i | input | 128 | Instruction bytes; byte k sits in bits 8k+7:8k, byte 0 first |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| len_o | output | 5 | Length of the first instruction in bytes, 0 on fault |
| fault_o | output | 1 | Encoding over 15 bytes or too many prefixes |

## Verification
Each field that the decoder gets wrong shifts the position of every field after it. A misread prefix, REX byte or escape therefore shows up as a length error at the ports in the very next cycle, often several bytes off. The cases are chosen so that each field size is isolated against a known reference: mod 3 with rm 4 (no SIB), SIB base 5 under mod 0, a 0x66 prefix with and without REX.W, and totals of exactly 15 and 16 bytes. A scoreboard pairs every window with its expected result. Idle gaps then confirm that the registered outputs do not drift.

// File: rtl/ild_pkg.sv
package ild_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {MAP_ONE, MAP_0F, MAP_0F38, MAP_0F3A} op_map_t;

  function automatic logic is_legacy_pfx(input byte_t b);
    case (b)
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
      8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

  function automatic logic is_rex(input byte_t b);
    return b[7:4] == 4'h4;
  endfunction
endpackage

// File: rtl/ild_prefix_scan.sv
module ild_prefix_scan
  import ild_pkg::*;
#(
  parameter int WIN_BYTES  = 16,
  parameter int MAX_LEGACY = 4,
  localparam int IDX_W     = $clog2(WIN_BYTES)
) (
  input  logic [WIN_BYTES*8-1:0] win_i,
  output logic [IDX_W-1:0]       npfx_o,
  output logic                   too_many_o,
  output logic                   opsz_o,
  output logic                   rex_o,
  output logic                   rex_w_o,
  output logic [IDX_W-1:0]       op_pos_o
);
  logic [MAX_LEGACY:0]   leg;
  logic [MAX_LEGACY-1:0] run;
  logic [MAX_LEGACY-1:0] saw66;
  byte_t                 rex_b;

  genvar i;
  generate
    for (i = 0; i <= MAX_LEGACY; i++) begin : g_leg
      assign leg[i] = is_legacy_pfx(win_i[i*8 +: 8]);
    end
    for (i = 0; i < MAX_LEGACY; i++) begin : g_run
      if (i == 0) begin : g_first
        assign run[i] = leg[i];
      end else begin : g_next
        assign run[i] = run[i-1] & leg[i];
      end
      assign saw66[i] = run[i] & (win_i[i*8 +: 8] == 8'h66);
    end
  endgenerate

  always_comb begin
    npfx_o     = IDX_W'($countones(run));
    too_many_o = run[MAX_LEGACY-1] & leg[MAX_LEGACY];
    opsz_o     = |saw66;
    rex_b      = win_i[npfx_o*8 +: 8];
    rex_o      = is_rex(rex_b);
    rex_w_o    = rex_o & rex_b[3];
    op_pos_o   = npfx_o + IDX_W'(rex_o);
  end
endmodule

// File: rtl/ild_body_size.sv
module ild_body_size
  import ild_pkg::*;
#(
  parameter int WIN_BYTES = 16,
  parameter int LEN_W     = 5,
  localparam int IDX_W    = $clog2(WIN_BYTES)
) (
  input  logic [WIN_BYTES*8-1:0] win_i,
  input  logic [IDX_W-1:0]       op_pos_i,
  input  logic                   opsz_i,
  input  logic                   rex_w_i,
  output logic [LEN_W-1:0]       body_len_o
);
  op_map_t          map;
  byte_t            b0, b1, modrm, sib_b;
  logic [IDX_W-1:0] mrm_pos;
  logic [1:0]       op_len;
  logic             has_modrm, has_sib;
  logic [3:0]       imm_len;
  logic [2:0]       disp_len;
  logic [1:0]       md;
  logic [2:0]       rm;
  logic             unused_bits;

  function automatic byte_t pick(input logic [IDX_W-1:0] idx);
    return win_i[idx*8 +: 8];
  endfunction

  always_comb begin
    b0 = pick(op_pos_i);
    b1 = pick(op_pos_i + IDX_W'(1));
    if (b0 != 8'h0F) begin
      map = MAP_ONE;  op_len = 2'd1;
    end else if (b1 == 8'h38) begin
      map = MAP_0F38; op_len = 2'd3;
    end else if (b1 == 8'h3A) begin
      map = MAP_0F3A; op_len = 2'd3;
    end else begin
      map = MAP_0F;   op_len = 2'd2;
    end

    has_modrm = 1'b1;
    imm_len   = 4'd0;
    case (map)
      MAP_ONE: begin
        if (b0 == 8'hC7) begin
          imm_len = (opsz_i && !rex_w_i) ? 4'd2 : 4'd4;
        end else if (b0[7:3] == 5'b10111) begin
          has_modrm = 1'b0;
          imm_len   = rex_w_i ? 4'd8 : (opsz_i ? 4'd2 : 4'd4);
        end
      end
      MAP_0F3A: imm_len = 4'd1;
      default:  imm_len = 4'd0;
    endcase

    mrm_pos  = op_pos_i + IDX_W'(op_len);
    modrm    = pick(mrm_pos);
    sib_b    = pick(mrm_pos + IDX_W'(1));
    md       = modrm[7:6];
    rm       = modrm[2:0];
    has_sib  = has_modrm && (md != 2'd3) && (rm == 3'd4);
    disp_len = 3'd0;
    if (has_modrm) begin
      case (md)
        2'd1:    disp_len = 3'd1;
        2'd2:    disp_len = 3'd4;
        2'd0:    if (rm == 3'd5 || (has_sib && sib_b[2:0] == 3'd5)) disp_len = 3'd4;
        default: disp_len = 3'd0;
      endcase
    end

    body_len_o = LEN_W'(op_len) + LEN_W'(has_modrm) + LEN_W'(has_sib)
               + LEN_W'(disp_len) + LEN_W'(imm_len);
    unused_bits = ^{modrm[5:3], sib_b[7:3]};
  end
endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
  import ild_pkg::*;
#(
  parameter int WIN_BYTES  = 16,
  parameter int MAX_LEGACY = 4,
  parameter int MAX_LEN    = 15,
  localparam int IDX_W     = $clog2(WIN_BYTES),
  localparam int LEN_W     = $clog2(2*WIN_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [WIN_BYTES*8-1:0] win_i,
  output logic                   out_valid,
  output logic [LEN_W-1:0]       len_o,
  output logic                   fault_o
);
  logic [IDX_W-1:0] npfx, op_pos;
  logic             too_many, opsz, rex, rex_w;
  logic [LEN_W-1:0] body_len, total;
  logic             bad;

  ild_prefix_scan #(.WIN_BYTES(WIN_BYTES), .MAX_LEGACY(MAX_LEGACY)) u_pfx (
    .win_i      (win_i),
    .npfx_o     (npfx),
    .too_many_o (too_many),
    .opsz_o     (opsz),
    .rex_o      (rex),
    .rex_w_o    (rex_w),
    .op_pos_o   (op_pos)
  );

  ild_body_size #(.WIN_BYTES(WIN_BYTES), .LEN_W(LEN_W)) u_body (
    .win_i      (win_i),
    .op_pos_i   (op_pos),
    .opsz_i     (opsz),
    .rex_w_i    (rex_w),
    .body_len_o (body_len)
  );

  always_comb begin
    total = LEN_W'(npfx) + LEN_W'(rex) + body_len;
    bad   = too_many || (total > LEN_W'(MAX_LEN));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      len_o     <= '0;
      fault_o   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        fault_o <= bad;
        len_o   <= bad ? '0 : total;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);  // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(len_o) && $stable(fault_o)));  // R2
  AST_FAULT_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && fault_o) |-> (len_o == '0));  // R11
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !fault_o) |-> (len_o >= LEN_W'(1) && len_o <= LEN_W'(MAX_LEN)));  // R11
endmodule

// File: tb/tb_insn_len_decoder.sv
`timescale 1ns/1ps
module tb_insn_len_decoder;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] win = '0;
  logic         out_valid;
  logic [4:0]   len_o;
  logic         fault_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [4:0] last_len = '0;
  logic       last_fault = 1'b0;

  typedef struct { logic [4:0] len; logic fault; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  insn_len_decoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .win_i(win),
    .out_valid(out_valid), .len_o(len_o), .fault_o(fault_o)
  );

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      n_tests++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected out_valid: actual len=%0d expected none", len_o);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (len_o !== e.len || fault_o !== e.fault) begin
          n_fail++;
          $display("FAIL %s: actual len=%0d fault=%0b expected len=%0d fault=%0b",
                   e.tag, len_o, fault_o, e.len, e.fault);
        end
      end
    end
  end

  task automatic send(input logic [127:0] bytes, input int n, input int len,
                      input bit flt, input string tag);
    logic [127:0] w;
    exp_t e;
    w = '0;
    for (int i = 0; i < n; i++) w[i*8 +: 8] = bytes[(n-1-i)*8 +: 8];
    @(negedge clk);
    in_valid = 1'b1;
    win      = w;
    e.len = 5'(len); e.fault = flt; e.tag = tag;
    q.push_back(e);
    last_len = 5'(len); last_fault = flt;
    @(negedge clk);
    in_valid = 1'b0;
    win      = '1;
  endtask

  task automatic check_idle(input string tag);
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0 || len_o !== last_len || fault_o !== last_fault) begin
      n_fail++;
      $display("FAIL %s hold: actual v=%0b len=%0d fault=%0b expected v=0 len=%0d fault=%0b",
               tag, out_valid, len_o, fault_o, last_len, last_fault);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0 || len_o !== 5'd0 || fault_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: actual v=%0b len=%0d fault=%0b expected 0 0 0",
               out_valid, len_o, fault_o);
    end
    rst = 1'b0;
    @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0 || len_o !== 5'd0 || fault_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 after reset: actual v=%0b len=%0d fault=%0b expected 0 0 0",
               out_valid, len_o, fault_o);
    end

    send(128'h48C7C011223344, 7, 7, 0, "R6 rexw c7");
    send(128'h48B98877665544332211, 10, 10, 0, "R7 rexw b8+r imm64");
    send(128'h66B83412, 4, 4, 0, "R7 opsz imm16");
    send(128'hB844332211, 5, 5, 0, "R7 imm32");
    check_idle("R2");
    send(128'h66C7003412, 5, 5, 0, "R6 opsz imm16");
    send(128'h6648C7C044332211, 8, 8, 0, "R6 R4 rexw overrides opsz");
    send(128'h89D8, 2, 2, 0, "R8 generic mod3");
    send(128'h8B4508, 3, 3, 0, "R10 disp8");
    send(128'h8B8544332211, 6, 6, 0, "R10 mod2 disp32");
    send(128'h8B0544332211, 6, 6, 0, "R10 mod0 rm5 disp32");
    send(128'h8B0424, 3, 3, 0, "R9 sib no disp");
    send(128'h8B042544332211, 7, 7, 0, "R9 R10 sib base5 disp32");
    send(128'h8B442408, 4, 4, 0, "R9 sib disp8");
    send(128'h8BC4, 2, 2, 0, "R9 mod3 rm4 no sib");
    send(128'h0FAFC1, 3, 3, 0, "R5 0f map");
    send(128'h0F3800C1, 4, 4, 0, "R5 0f38 map");
    send(128'h0F3A0FC108, 5, 5, 0, "R5 R8 0f3a imm8");
    send(128'hF0F32E6789D8, 6, 6, 0, "R3 four prefixes");
    send(128'h4C89C8, 3, 3, 0, "R4 rex no w");
    send(128'h65642636_3E89D8, 7, 0, 1, "R3 R11 fifth prefix");
    check_idle("R2 fault hold");
    send(128'hF2662E6748C7842444332211_88776655, 16, 0, 1, "R11 sixteen bytes");
    send(128'h66672EF3480F3A0F842444332211_08, 15, 15, 0, "R11 fifteen bytes");
    check_idle("R2 final");

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL R2 missing results: actual %0d pending expected 0", q.size());
    end
    finish_run();
  end
endmodule